// File: doc/BRIEF.md
# Boost Converter Start-up Sequencer

This block brings a boost converter up from rest in a fixed order and takes it down again on a fault. Once enable is high and the supply is above its undervoltage limit, the block waits for the switch node to report that its start-up voltage check has passed. It then closes the output protection switch and counts out an inrush window. After that window it lets the converter switch and raises the inductor current limit one code step at a time until the limit reaches its top value.

All timing comes from a one-cycle millisecond tick input. Each current-limit step lasts a set number of ticks. When the LED dimming duty is reported low, each step lasts a longer, separately set number of ticks, so the output capacitor has time to charge.

Enable must stay low for a set time before the block shuts down. An undervoltage flag restarts the sequence at once. A start-up check that never passes, or an output that first comes up and then collapses while the protection switch is closed, moves the block into a latched fault. Only reset clears the latched fault.

Top module: `boost_startup_seq`

## Requirements
- R1: After reset, `protFetEn`, `boostEn` and `ilimCode` are all 0. They stay 0 until `enable` is 1 and `uvFlag` is 0 in the same cycle.
- R2: While the switch-node check (`swStartOk`) has not passed, `protFetEn` stays 0. The cycle after `swStartOk` is seen, `protFetEn` becomes 1, with `boostEn` still 0.
- R3: If `swStartOk` stays 0 for CHECK_TO_MS ticks after the check begins, the block enters a latched fault with all outputs 0.
- R4: `boostEn` rises on the cycle after the INRUSH_MS-th tick counted with the protection switch on. At that point `ilimCode` is 0.
- R5: `ilimCode` encodes a current limit of (code+1) x 275 mA. During the ramp it rises by exactly 1 every STEP_MS ticks and never skips a value.
- R6: While `lowDuty` is 1, each step lasts STEP_LOW_MS ticks instead of STEP_MS. A step ends on the first tick whose count reaches the length currently selected.
- R7: After code 6 has lasted a full step, the code becomes 7 (2.2 A). It holds there while running.
- R8: If `enable` is low for fewer than EN_OFF_MS ticks, nothing changes. On the EN_OFF_MS-th tick with `enable` low, all outputs return to 0. A new start needs `enable` high.
- R9: `uvFlag` set in any state other than the latched fault returns all outputs to 0 on the next cycle. The sequence starts again once `uvFlag` clears.
- R10: If `voutAbove` is seen at 1 while the protection switch is on, and later falls to 0, the block latches a fault with all outputs 0. `enable` and `uvFlag` cannot clear this fault; only reset can.
- R11: `boostEn` is never 1 without `protFetEn`, and `ilimCode` is never nonzero without `boostEn`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low (power cycle) |
| enable | input | 1 | Converter enable request |
| uvFlag | input | 1 | Supply below undervoltage limit |
| swStartOk | input | 1 | Switch node above its start-up check level |
| voutAbove | input | 1 | Output above 20% of the overvoltage level |
| lowDuty | input | 1 | LED dimming duty is low; stretch each step |
| msTick | input | 1 | One-cycle pulse every millisecond |
| protFetEn | output | 1 | Protection switch gate enable |
| boostEn | output | 1 | Boost switching allowed |
| ilimCode | output | STEP_W | Current-limit step code |

## Verification
The bench builds the block with short windows: 3 ticks of inrush, 2-tick and 4-tick steps, a 5-tick enable-low filter and a 6-tick check timeout. It drives a tick every 4 clocks. With these values a full ramp, a stretched ramp, a filtered enable glitch, a real enable shutdown, an undervoltage restart and both latched-fault paths all fit in a short run. The bench also switches `lowDuty` in the middle of a step, so it exercises the rule that a step ends as soon as its count reaches the newly selected length.

// File: rtl/boost_seq_pkg.sv
package boost_seq_pkg;

  typedef enum logic [2:0] {
    ST_OFF,
    ST_CHECK,
    ST_INRUSH,
    ST_SOFT,
    ST_RUN,
    ST_LATCH
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clrTimer;
    logic incStep;
    logic clrStep;
    logic clrArm;
    logic fetOn;
  } seqStrobe_t;

endpackage

// File: rtl/boost_seq_dp.sv
module boost_seq_dp
  import boost_seq_pkg::*;
#(
  parameter int INRUSH_MS   = 4,
  parameter int STEP_MS     = 2,
  parameter int STEP_LOW_MS = 4,
  parameter int EN_OFF_MS   = 28,
  parameter int CHECK_TO_MS = 31,
  parameter int STEP_W      = 3,
  parameter int CW          = 6
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              msTick,
  input  logic              enable,
  input  logic              voutAbove,
  input  logic              lowDuty,
  input  seqStrobe_t        strobe,
  output logic [STEP_W-1:0] stepCode,
  output logic              checkExpired,
  output logic              inrushDone,
  output logic              dwellDone,
  output logic              enOffDone,
  output logic              shortSeen
);

  localparam logic [CW:0] LIM_INRUSH = (CW+1)'(INRUSH_MS);
  localparam logic [CW:0] LIM_STEP   = (CW+1)'(STEP_MS);
  localparam logic [CW:0] LIM_LOW    = (CW+1)'(STEP_LOW_MS);
  localparam logic [CW:0] LIM_ENOFF  = (CW+1)'(EN_OFF_MS);
  localparam logic [CW:0] LIM_CHECK  = (CW+1)'(CHECK_TO_MS);
  localparam logic [CW-1:0] CNT_TOP  = {CW{1'b1}};
  localparam logic [CW-1:0] EN_SAT   = CW'(EN_OFF_MS);

  logic [CW-1:0] msCnt;
  logic [CW-1:0] enLowCnt;
  logic          armed;
  logic [CW:0]   msCntNext;
  logic [CW:0]   enLowNext;
  logic [CW:0]   dwellLim;

  // phase timer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               msCnt <= '0;
    else if (strobe.clrTimer) msCnt <= '0;
    else if (msTick && msCnt != CNT_TOP) msCnt <= msCnt + 1'b1;
  end

  // enable-low filter counter
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      enLowCnt <= '0;
    else if (enable) enLowCnt <= '0;
    else if (msTick && enLowCnt != EN_SAT) enLowCnt <= enLowCnt + 1'b1;
  end

  // current-limit step code
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              stepCode <= '0;
    else if (strobe.clrStep) stepCode <= '0;
    else if (strobe.incStep) stepCode <= stepCode + 1'b1;
  end

  // output-short detector: armed once output is up with FET closed
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             armed <= 1'b0;
    else if (strobe.clrArm) armed <= 1'b0;
    else if (strobe.fetOn && voutAbove) armed <= 1'b1;
  end

  always_comb begin
    msCntNext    = {1'b0, msCnt} + {{CW{1'b0}}, 1'b1};
    enLowNext    = {1'b0, enLowCnt} + {{CW{1'b0}}, 1'b1};
    dwellLim     = lowDuty ? LIM_LOW : LIM_STEP;
    checkExpired = msTick && (msCntNext >= LIM_CHECK);
    inrushDone   = msTick && (msCntNext >= LIM_INRUSH);
    dwellDone    = msTick && (msCntNext >= dwellLim);
    enOffDone    = !enable && msTick && (enLowNext >= LIM_ENOFF);
    shortSeen    = armed && !voutAbove;
  end

  // R5: code moves only by one step up or back to zero
  assert_step_by_one_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (stepCode != $past(stepCode)) |->
      ((stepCode == ($past(stepCode) + STEP_W'(1))) || (stepCode == '0)));

endmodule

// File: rtl/boost_seq_ctrl.sv
module boost_seq_ctrl
  import boost_seq_pkg::*;
#(
  parameter int STEP_W = 3
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              uvFlag,
  input  logic              swStartOk,
  input  logic [STEP_W-1:0] stepCode,
  input  logic              checkExpired,
  input  logic              inrushDone,
  input  logic              dwellDone,
  input  logic              enOffDone,
  input  logic              shortSeen,
  output seqStrobe_t        strobe,
  output logic              protFetEn,
  output logic              boostEn
);

  localparam logic [STEP_W-1:0] MAX_CODE  = {STEP_W{1'b1}};
  localparam logic [STEP_W-1:0] LAST_RAMP = MAX_CODE - 1'b1;

  seqState_t st, nextSt;
  logic fetState, nextRamp, nextFet;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_OFF;
    else        st <= nextSt;
  end

  always_comb begin
    nextSt = st;
    if (st == ST_LATCH)                  nextSt = ST_LATCH;
    else if (st != ST_OFF && uvFlag)     nextSt = ST_OFF;
    else if (st != ST_OFF && enOffDone)  nextSt = ST_OFF;
    else if (shortSeen)                  nextSt = ST_LATCH;
    else begin
      unique case (st)
        ST_OFF:    if (enable && !uvFlag) nextSt = ST_CHECK;
        ST_CHECK:  if (swStartOk)         nextSt = ST_INRUSH;
                   else if (checkExpired) nextSt = ST_LATCH;
        ST_INRUSH: if (inrushDone)        nextSt = ST_SOFT;
        ST_SOFT:   if (dwellDone && stepCode == LAST_RAMP) nextSt = ST_RUN;
        ST_RUN:    nextSt = ST_RUN;
        default:   nextSt = ST_LATCH;
      endcase
    end
  end

  always_comb begin
    fetState = (st == ST_INRUSH) || (st == ST_SOFT) || (st == ST_RUN);
    nextRamp = (nextSt == ST_SOFT) || (nextSt == ST_RUN);
    nextFet  = nextRamp || (nextSt == ST_INRUSH);
    protFetEn = fetState;
    boostEn   = (st == ST_SOFT) || (st == ST_RUN);
    strobe.fetOn    = fetState;
    strobe.clrTimer = (nextSt != st) || ((st == ST_SOFT) && dwellDone);
    strobe.incStep  = (st == ST_SOFT) && dwellDone && nextRamp;
    strobe.clrStep  = !nextRamp;
    strobe.clrArm   = !nextFet;
  end

  // R9: undervoltage drops the sequence on the next edge
  assert_uv_resets_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (uvFlag && st != ST_LATCH) |=> (st == ST_OFF && !boostEn));

  // R11: switching only with the protection switch closed
  assert_fet_under_boost_R11: assert property (@(posedge clk) disable iff (!rst_n)
    boostEn |-> protFetEn);

  // R4: switching can only start out of the inrush window
  assert_boost_after_inrush_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(boostEn) |-> ($past(st) == ST_INRUSH && stepCode == '0));

  // R7: running means the top current-limit code
  assert_run_at_max_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RUN) |-> (stepCode == MAX_CODE));

  // R2: FET stays open while the switch-node check fails
  assert_fet_waits_check_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_CHECK && !swStartOk) |=> !protFetEn);

endmodule

// File: rtl/boost_startup_seq.sv
module boost_startup_seq
  import boost_seq_pkg::*;
#(
  parameter int INRUSH_MS   = 4,
  parameter int STEP_MS     = 2,
  parameter int STEP_LOW_MS = 4,
  parameter int EN_OFF_MS   = 28,
  parameter int CHECK_TO_MS = 31,
  parameter int STEP_W      = 3
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              uvFlag,
  input  logic              swStartOk,
  input  logic              voutAbove,
  input  logic              lowDuty,
  input  logic              msTick,
  output logic              protFetEn,
  output logic              boostEn,
  output logic [STEP_W-1:0] ilimCode
);

  localparam int MAX_A  = (INRUSH_MS > STEP_MS) ? INRUSH_MS : STEP_MS;
  localparam int MAX_B  = (STEP_LOW_MS > EN_OFF_MS) ? STEP_LOW_MS : EN_OFF_MS;
  localparam int MAX_AB = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int MAX_L  = (MAX_AB > CHECK_TO_MS) ? MAX_AB : CHECK_TO_MS;
  localparam int CW     = $clog2(MAX_L + 2);

  seqStrobe_t strobe;
  logic checkExpired, inrushDone, dwellDone, enOffDone, shortSeen;

  boost_seq_dp #(
    .INRUSH_MS(INRUSH_MS), .STEP_MS(STEP_MS), .STEP_LOW_MS(STEP_LOW_MS),
    .EN_OFF_MS(EN_OFF_MS), .CHECK_TO_MS(CHECK_TO_MS), .STEP_W(STEP_W), .CW(CW)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .msTick(msTick), .enable(enable),
    .voutAbove(voutAbove), .lowDuty(lowDuty), .strobe(strobe),
    .stepCode(ilimCode), .checkExpired(checkExpired), .inrushDone(inrushDone),
    .dwellDone(dwellDone), .enOffDone(enOffDone), .shortSeen(shortSeen)
  );

  boost_seq_ctrl #(.STEP_W(STEP_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .enable(enable), .uvFlag(uvFlag),
    .swStartOk(swStartOk), .stepCode(ilimCode), .checkExpired(checkExpired),
    .inrushDone(inrushDone), .dwellDone(dwellDone), .enOffDone(enOffDone),
    .shortSeen(shortSeen), .strobe(strobe), .protFetEn(protFetEn),
    .boostEn(boostEn)
  );

endmodule

// File: tb/boost_startup_seq_test.sv
`timescale 1ns/1ps
module boost_startup_seq_test;

  localparam int INR = 3, STP = 2, STPL = 4, ENOFF = 5, CHKTO = 6;

  logic clk = 0, rst_n = 0;
  logic enable = 0, uvFlag = 0, swStartOk = 0, voutAbove = 0, lowDuty = 0, msTick = 0;
  logic protFetEn, boostEn;
  logic [2:0] ilimCode;

  always #10 clk = ~clk;

  boost_startup_seq #(.INRUSH_MS(INR), .STEP_MS(STP), .STEP_LOW_MS(STPL),
    .EN_OFF_MS(ENOFF), .CHECK_TO_MS(CHKTO), .STEP_W(3)) uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .uvFlag(uvFlag),
    .swStartOk(swStartOk), .voutAbove(voutAbove), .lowDuty(lowDuty),
    .msTick(msTick), .protFetEn(protFetEn), .boostEn(boostEn), .ilimCode(ilimCode));

  integer tests = 0, fails = 0, cyc = 0, tickDiv = 0;
  string tag = "R1";
  bit done = 0;

  // behavioural reference: 0 off,1 check,2 inrush,3 ramp,4 run,5 latched
  integer mSt = 0, mCnt = 0, mEnLow = 0, mCode = 0, mNxt;
  bit mArmed = 0, mEnOff, mShort, mFet, mStep;

  always @(posedge clk) begin
    if (!rst_n) begin
      mSt = 0; mCnt = 0; mEnLow = 0; mCode = 0; mArmed = 0;
    end else begin
      mEnOff = !enable && msTick && (mEnLow + 1 >= ENOFF);
      mShort = mArmed && !voutAbove;
      mFet   = (mSt >= 2 && mSt <= 4);
      mNxt = mSt; mStep = 0;
      if (mSt == 5) mNxt = 5;
      else if (mSt != 0 && uvFlag) mNxt = 0;
      else if (mSt != 0 && mEnOff) mNxt = 0;
      else if (mShort) mNxt = 5;
      else if (mSt == 0) begin if (enable && !uvFlag) mNxt = 1; end
      else if (mSt == 1) begin
        if (swStartOk) mNxt = 2;
        else if (msTick && mCnt + 1 >= CHKTO) mNxt = 5;
      end
      else if (mSt == 2) begin if (msTick && mCnt + 1 >= INR) mNxt = 3; end
      else if (mSt == 3) begin
        if (msTick && mCnt + 1 >= (lowDuty ? STPL : STP)) begin
          mStep = 1;
          if (mCode == 6) mNxt = 4;
        end
      end
      if (mNxt >= 2 && mNxt <= 4) mArmed = mArmed || (voutAbove && mFet);
      else mArmed = 0;
      if (!(mNxt == 3 || mNxt == 4)) mCode = 0;
      else if (mStep) mCode = mCode + 1;
      if (mNxt != mSt || mStep) mCnt = 0;
      else if (msTick) mCnt = mCnt + 1;
      if (enable) mEnLow = 0;
      else if (msTick) mEnLow = mEnLow + 1;
      mSt = mNxt;
    end
  end

  // compare every cycle at the falling edge, then advance the tick
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (!done) begin
        tests++;
        if (protFetEn !== (mSt >= 2 && mSt <= 4) || boostEn !== (mSt == 3 || mSt == 4)
            || ilimCode !== mCode[2:0]) begin
          fails++;
          $display("FAIL %s cyc %0d: fet/boost/code actual %b/%b/%0d expected %b/%b/%0d",
            tag, cyc, protFetEn, boostEn, ilimCode,
            (mSt >= 2 && mSt <= 4), (mSt == 3 || mSt == 4), mCode);
        end
        tests++;  // R11 structural relation at the ports
        if ((boostEn && !protFetEn) || (ilimCode != 0 && !boostEn)) begin
          fails++;
          $display("FAIL R11 cyc %0d: fet/boost/code actual %b/%b/%0d expected consistent",
            cyc, protFetEn, boostEn, ilimCode);
        end
      end
      tickDiv = (tickDiv + 1) % 4;
      msTick = (tickDiv == 0);
      if (cyc > 100000 && !done) begin
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    end
  end

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    tag = "R1";
    waitCyc(5); rst_n = 1;
    waitCyc(20);                         // enable low: stays off
    tag = "R2"; enable = 1; waitCyc(12); // check fails, FET open
    swStartOk = 1;
    tag = "R4"; waitCyc(16);
    tag = "R5"; waitCyc(60);
    tag = "R7"; waitCyc(30);
    tag = "R8"; enable = 0; waitCyc(12); // short glitch ignored
    enable = 1; waitCyc(10);
    enable = 0; waitCyc(30);             // long low: shutdown
    tag = "R6"; enable = 1; lowDuty = 1; waitCyc(61);
    lowDuty = 0; waitCyc(80);            // switch length mid-step
    tag = "R7"; waitCyc(20);
    tag = "R9"; uvFlag = 1; waitCyc(6);
    uvFlag = 0; waitCyc(120);
    tag = "R10"; voutAbove = 1; waitCyc(10);
    voutAbove = 0; waitCyc(20);
    enable = 0; waitCyc(30); enable = 1; uvFlag = 1; waitCyc(5); uvFlag = 0; waitCyc(30);
    tag = "R1"; rst_n = 0; swStartOk = 0; waitCyc(3); rst_n = 1; waitCyc(3);
    tag = "R3"; waitCyc(40);
    swStartOk = 1; waitCyc(20);          // latched: check pass has no effect
    tag = "R1"; rst_n = 0; waitCyc(3); rst_n = 1; waitCyc(40);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule